// File: doc/BRIEF.md
# Bus Comparator Event Unit

This block watches the buses of a CPU core with a set of comparator channels. Each channel picks one source (program fetch address, data read address, data write address, data write data or the virtual program counter) and compares it against a programmed reference value. A don't-care mask lets whole address ranges or bit fields match. What a channel does when it matches depends on its mode. It can raise a code breakpoint, a data watchpoint, a trace tag or a direct real-time interrupt request.

Matches on instruction fetches are not acted on at once. They are stored as tags against the fetch-buffer slot that received the instruction. They are resolved when that slot's instruction enters the second decode stage, and a pipeline flush throws them away. Data watchpoints wait for the next interruptible boundary before requesting a halt. Separately, the match lines of all channels feed four AND groups and four OR groups, each with its own channel mask. These combined events are exported and can each be routed to the interrupt request. The CPU pipeline is not modelled: it is seen only through fetch, decode-2 and flush strobes.

Top module: `bus_cmp_events`

## Requirements
- R1: Channel i matches when its source is valid and `((bus ^ ref) & ~dc) == 0`, where `dc` bits are don't-care. The source codes are 0 program address (valid on `fetch_vld`), 1 read address (`rd_vld`), 2 write address (`wr_vld`), 3 write data (`wr_vld`), 4 virtual PC (`vpc_vld`), and 5 to 7 never match. `match_q[i]` shows the match one clock later.
- R2: The mode codes are 0 breakpoint, 1 watchpoint, 2 trace and 3 interrupt. A breakpoint or trace channel tags an instruction only in a cycle with `fetch_vld` high. The tag goes to slot `fetch_slot` and replaces whatever that slot held before.
- R3: `dec2_go` without `flush` consumes slot `dec2_slot`. If that slot holds a breakpoint tag and `dbg_attached` is high, `halt_req` pulses on the next cycle. With `dbg_attached` low the tag is consumed and has no effect.
- R4: A trace tag consumed at decode-2 pulses `rti_req` on the next cycle and never `halt_req`.
- R5: `flush` clears every tag. A decode-2 or a fetch that comes in the same cycle as the flush produces no request and leaves no tag.
- R6: A watchpoint match sets a pending flag. `halt_req` pulses one cycle after the first `int_boundary` cycle that comes after the match cycle, and that halt clears the flag.
- R7: An interrupt-mode channel match pulses `rti_req` on the next cycle.
- R8: AND event k (`and_sel` bits [k*NCH +: NCH]) is high one cycle after every selected channel matched. It stays low when its selection is empty.
- R9: OR event k (`or_sel` bits [k*NCH +: NCH]) is high one cycle after any selected channel matched.
- R10: Bit k of `evt_to_rti` routes AND event k, and bit 4+k routes OR event k. A routed event raises `rti_req` in the same cycle that the event appears.
- R11: While `rst_n` is low, every output is low and all tags and pending flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_addr | input | W | Program fetch address |
| fetch_vld | input | 1 | Fetch strobe; qualifies prog_addr |
| rd_addr | input | W | Data read address |
| rd_vld | input | 1 | Read strobe |
| wr_addr | input | W | Data write address |
| wr_data | input | W | Data write value |
| wr_vld | input | 1 | Write strobe |
| vpc | input | W | Virtual program counter |
| vpc_vld | input | 1 | Virtual PC valid |
| ch_src | input | 3*NCH | Source code per channel |
| ch_mode | input | 2*NCH | Mode code per channel |
| ch_ref | input | W*NCH | Reference value per channel |
| ch_dc | input | W*NCH | Don't-care mask per channel |
| fetch_slot | input | log2(DEPTH) | Slot receiving the fetched instruction |
| dec2_go | input | 1 | Instruction enters decode-2 |
| dec2_slot | input | log2(DEPTH) | Slot of the instruction entering decode-2 |
| flush | input | 1 | Fetch buffer discarded |
| dbg_attached | input | 1 | Debugger present |
| int_boundary | input | 1 | Interruptible boundary reached |
| and_sel | input | 4*NCH | Channel masks of the AND groups |
| or_sel | input | 4*NCH | Channel masks of the OR groups |
| evt_to_rti | input | 8 | Routes combined events to the interrupt |
| match_q | output | NCH | Registered channel matches |
| and_evt | output | 4 | AND group events |
| or_evt | output | 4 | OR group events |
| halt_req | output | 1 | Halt request pulse |
| rti_req | output | 1 | Real-time interrupt request pulse |

## Verification
Two collisions matter most. A breakpoint tag can resolve at decode-2 in the same cycle that a pending watchpoint meets its interruptible boundary. A trace tag can resolve in the same cycle that an interrupt-mode channel or a routed combined event fires. In both cases the expected output is a single merged pulse, not a dropped one. Random decode-2, boundary and strobe patterns make these coincidences happen often, and a bench model checks every output in every cycle. Directed cases then line up a decode-2 with a flush, and a watchpoint match with a boundary in the same cycle; in both the request must be held back.

// File: rtl/bus_cmp_events.sv
module bus_cmp_events #(
  parameter int NCH   = 4,
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int SW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NGRP = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        prog_addr,
  input  logic                fetch_vld,
  input  logic [W-1:0]        rd_addr,
  input  logic                rd_vld,
  input  logic [W-1:0]        wr_addr,
  input  logic [W-1:0]        wr_data,
  input  logic                wr_vld,
  input  logic [W-1:0]        vpc,
  input  logic                vpc_vld,
  input  logic [NCH*3-1:0]    ch_src,
  input  logic [NCH*2-1:0]    ch_mode,
  input  logic [NCH*W-1:0]    ch_ref,
  input  logic [NCH*W-1:0]    ch_dc,
  input  logic [SW-1:0]       fetch_slot,
  input  logic                dec2_go,
  input  logic [SW-1:0]       dec2_slot,
  input  logic                flush,
  input  logic                dbg_attached,
  input  logic                int_boundary,
  input  logic [NGRP*NCH-1:0] and_sel,
  input  logic [NGRP*NCH-1:0] or_sel,
  input  logic [2*NGRP-1:0]   evt_to_rti,
  output logic [NCH-1:0]      match_q,
  output logic [NGRP-1:0]     and_evt,
  output logic [NGRP-1:0]     or_evt,
  output logic                halt_req,
  output logic                rti_req
);
  localparam logic [1:0] M_BP = 2'd0, M_WP = 2'd1, M_TR = 2'd2, M_RTI = 2'd3;

  logic [NCH-1:0] hit, is_bp, is_wp, is_tr, is_rti;
  logic [NGRP-1:0] and_now, or_now;
  logic [DEPTH-1:0] bp_tag, tr_tag;
  logic wp_pend;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [W-1:0] bus;
    logic         vld;
    always_comb begin
      bus = '0;
      vld = 1'b0;
      case (ch_src[i*3 +: 3])
        3'd0: begin bus = prog_addr; vld = fetch_vld; end
        3'd1: begin bus = rd_addr;   vld = rd_vld;    end
        3'd2: begin bus = wr_addr;   vld = wr_vld;    end
        3'd3: begin bus = wr_data;   vld = wr_vld;    end
        3'd4: begin bus = vpc;       vld = vpc_vld;   end
        default: ;
      endcase
    end
    assign hit[i]    = vld && (((bus ^ ch_ref[i*W +: W]) & ~ch_dc[i*W +: W]) == '0);
    assign is_bp[i]  = ch_mode[i*2 +: 2] == M_BP;
    assign is_wp[i]  = ch_mode[i*2 +: 2] == M_WP;
    assign is_tr[i]  = ch_mode[i*2 +: 2] == M_TR;
    assign is_rti[i] = ch_mode[i*2 +: 2] == M_RTI;
  end

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    logic [NCH-1:0] am, om;
    assign am = and_sel[k*NCH +: NCH];
    assign om = or_sel[k*NCH +: NCH];
    assign and_now[k] = (|am) && ((hit & am) == am);
    assign or_now[k]  = |(hit & om);
  end

  wire bp_new  = fetch_vld && |(hit & is_bp);
  wire tr_new  = fetch_vld && |(hit & is_tr);
  wire consume = dec2_go && !flush;
  wire bp_fire = consume && bp_tag[dec2_slot] && dbg_attached;
  wire tr_fire = consume && tr_tag[dec2_slot];
  wire wp_hit  = |(hit & is_wp);
  wire rti_hit = |(hit & is_rti);
  wire evt_rti = |({or_now, and_now} & evt_to_rti);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_tag <= '0;
      tr_tag <= '0;
    end else if (flush) begin
      bp_tag <= '0;
      tr_tag <= '0;
    end else begin
      if (dec2_go) begin
        bp_tag[dec2_slot] <= 1'b0;
        tr_tag[dec2_slot] <= 1'b0;
      end
      if (fetch_vld) begin
        bp_tag[fetch_slot] <= bp_new;
        tr_tag[fetch_slot] <= tr_new;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_pend  <= 1'b0;
      halt_req <= 1'b0;
      rti_req  <= 1'b0;
      match_q  <= '0;
      and_evt  <= '0;
      or_evt   <= '0;
    end else begin
      wp_pend  <= (wp_pend && !int_boundary) || wp_hit;
      halt_req <= bp_fire || (wp_pend && int_boundary);
      rti_req  <= tr_fire || rti_hit || evt_rti;
      match_q  <= hit;
      and_evt  <= and_now;
      or_evt   <= or_now;
    end
  end
endmodule

// File: rtl/bus_cmp_events_chk.sv
module bus_cmp_events_chk #(
  parameter int NCH  = 4,
  parameter int NGRP = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dec2_go,
  input logic                flush,
  input logic                dbg_attached,
  input logic                int_boundary,
  input logic [NGRP*NCH-1:0] and_sel,
  input logic [NGRP*NCH-1:0] or_sel,
  input logic [NCH-1:0]      match_q,
  input logic [NGRP-1:0]     and_evt,
  input logic [NGRP-1:0]     or_evt,
  input logic                halt_req,
  input logic                rti_req
);
  assert_halt_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> ($past(int_boundary) ||
                  ($past(dec2_go) && $past(dbg_attached) && !$past(flush))));

  assert_flush_no_bp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !int_boundary) |=> !halt_req);

  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_n |=> (!halt_req && !rti_req && match_q == '0 && and_evt == '0 && or_evt == '0));

  for (genvar k = 0; k < NGRP; k++) begin : g_k
    assert_and_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      and_evt[k] |-> ($past(and_sel[k*NCH +: NCH]) != '0));
    assert_and_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
      and_evt[k] |-> ((match_q & $past(and_sel[k*NCH +: NCH])) == $past(and_sel[k*NCH +: NCH])));
    assert_or_any_R9: assert property (@(posedge clk) disable iff (!rst_n)
      or_evt[k] |-> ((match_q & $past(or_sel[k*NCH +: NCH])) != '0));
  end
endmodule

bind bus_cmp_events bus_cmp_events_chk #(.NCH(NCH), .NGRP(NGRP)) u_chk (.*);

// File: tb/bus_cmp_events_test.sv
module bus_cmp_events_test;
  localparam int NCH = 4, W = 32, DEPTH = 4, SW = 2, NGRP = 4;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] prog_addr, rd_addr, wr_addr, wr_data, vpc;
  logic fetch_vld, rd_vld, wr_vld, vpc_vld, dec2_go, flush, dbg_attached, int_boundary;
  logic [NCH*3-1:0] ch_src;
  logic [NCH*2-1:0] ch_mode;
  logic [NCH*W-1:0] ch_ref, ch_dc;
  logic [SW-1:0] fetch_slot, dec2_slot;
  logic [NGRP*NCH-1:0] and_sel, or_sel;
  logic [2*NGRP-1:0] evt_to_rti;
  logic [NCH-1:0] match_q;
  logic [NGRP-1:0] and_evt, or_evt;
  logic halt_req, rti_req;

  bus_cmp_events #(.NCH(NCH), .W(W), .DEPTH(DEPTH)) uut (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [DEPTH-1:0] mbp, mtr;
  logic mwp;
  logic [NCH-1:0] e_match;
  logic [NGRP-1:0] e_and, e_or;
  logic e_halt, e_rti;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit chm(int i);
    logic [W-1:0] b; bit v;
    case (ch_src[i*3 +: 3])
      3'd0: begin b = prog_addr; v = fetch_vld; end
      3'd1: begin b = rd_addr;   v = rd_vld;    end
      3'd2: begin b = wr_addr;   v = wr_vld;    end
      3'd3: begin b = wr_data;   v = wr_vld;    end
      3'd4: begin b = vpc;       v = vpc_vld;   end
      default: begin b = '0; v = 0; end
    endcase
    return v && (((b ^ ch_ref[i*W +: W]) & ~ch_dc[i*W +: W]) == '0);
  endfunction

  task automatic idle();
    fetch_vld = 0; rd_vld = 0; wr_vld = 0; vpc_vld = 0;
    dec2_go = 0; flush = 0; int_boundary = 0;
  endtask

  task automatic step();
    logic [NCH-1:0] h; bit bpn, trn, wph, rtih, bpf, trf;
    for (int i = 0; i < NCH; i++) h[i] = chm(i);
    bpn = 0; trn = 0; wph = 0; rtih = 0;
    for (int i = 0; i < NCH; i++) begin
      bpn  |= h[i] && ch_mode[i*2 +: 2] == 2'd0 && fetch_vld;
      wph  |= h[i] && ch_mode[i*2 +: 2] == 2'd1;
      trn  |= h[i] && ch_mode[i*2 +: 2] == 2'd2 && fetch_vld;
      rtih |= h[i] && ch_mode[i*2 +: 2] == 2'd3;
    end
    for (int k = 0; k < NGRP; k++) begin
      logic [NCH-1:0] am, om;
      am = and_sel[k*NCH +: NCH]; om = or_sel[k*NCH +: NCH];
      e_and[k] = am != 0 && (h & am) == am;
      e_or[k]  = (h & om) != 0;
    end
    e_match = h;
    bpf = dec2_go && !flush && mbp[dec2_slot] && dbg_attached;
    trf = dec2_go && !flush && mtr[dec2_slot];
    e_halt = bpf || (mwp && int_boundary);
    e_rti  = trf || rtih || (({e_or, e_and} & evt_to_rti) != 0);
    mwp = (mwp && !int_boundary) || wph;
    if (flush) begin mbp = 0; mtr = 0; end
    else begin
      if (dec2_go) begin mbp[dec2_slot] = 0; mtr[dec2_slot] = 0; end
      if (fetch_vld) begin mbp[fetch_slot] = bpn; mtr[fetch_slot] = trn; end
    end
    @(negedge clk);
    chk(match_q == e_match, "R1 match", 32'(match_q), 32'(e_match));
    chk(and_evt == e_and, "R8 and", 32'(and_evt), 32'(e_and));
    chk(or_evt == e_or, "R9 or", 32'(or_evt), 32'(e_or));
    chk(halt_req == e_halt, "R3 R6 halt", 32'(halt_req), 32'(e_halt));
    chk(rti_req == e_rti, "R4 R7 R10 rti", 32'(rti_req), 32'(e_rti));
  endtask

  task automatic setch(int i, logic [2:0] s, logic [1:0] m, logic [W-1:0] r, logic [W-1:0] d);
    ch_src[i*3 +: 3] = s; ch_mode[i*2 +: 2] = m; ch_ref[i*W +: W] = r; ch_dc[i*W +: W] = d;
  endtask

  task automatic fetch_dec(logic [W-1:0] a, logic [SW-1:0] s, bit dbg);
    idle(); fetch_vld = 1; prog_addr = a; fetch_slot = s; step();
    idle(); dec2_go = 1; dec2_slot = s; dbg_attached = dbg; step();
  endtask

  initial begin
    void'($urandom(32'd1234));
    idle();
    prog_addr = 0; rd_addr = 0; wr_addr = 0; wr_data = 0; vpc = 0;
    ch_src = '1; ch_mode = 0; ch_ref = 0; ch_dc = 0;
    fetch_slot = 0; dec2_slot = 0; dbg_attached = 0;
    and_sel = 0; or_sel = 0; evt_to_rti = 0;
    mbp = 0; mtr = 0; mwp = 0;
    repeat (3) @(negedge clk);
    chk(!halt_req && !rti_req && match_q == 0 && and_evt == 0 && or_evt == 0, "R11 reset", 32'(halt_req), 0);
    rst_n = 1;
    @(negedge clk);

    // R3 breakpoint without debugger, then with
    setch(0, 3'd0, 2'd0, 32'h100, 0);
    fetch_dec(32'h100, 2'd1, 0);
    chk(halt_req == 0, "R3 no debugger", 32'(halt_req), 0);
    fetch_dec(32'h100, 2'd2, 1);
    chk(halt_req == 1, "R3 debugger halt", 32'(halt_req), 1);
    // R1 don't-care bits and R2 fetch-only tagging
    setch(0, 3'd0, 2'd0, 32'h100, 32'hF);
    fetch_dec(32'h10A, 2'd0, 1);
    chk(halt_req == 1, "R1 dont-care", 32'(halt_req), 1);
    // R4 trace
    setch(0, 3'd0, 2'd2, 32'h300, 0);
    fetch_dec(32'h300, 2'd3, 1);
    chk(rti_req == 1 && halt_req == 0, "R4 trace", {rti_req, halt_req}, 2'b10);
    // R5 flush cancels a tag
    idle(); fetch_vld = 1; prog_addr = 32'h300; fetch_slot = 1; step();
    idle(); flush = 1; step();
    idle(); dec2_go = 1; dec2_slot = 1; step();
    chk(rti_req == 0, "R5 flush", 32'(rti_req), 0);
    // R5 flush in the decode-2 cycle
    idle(); fetch_vld = 1; prog_addr = 32'h300; fetch_slot = 2; step();
    idle(); dec2_go = 1; dec2_slot = 2; flush = 1; step();
    chk(rti_req == 0, "R5 flush same cycle", 32'(rti_req), 0);
    // R6 watchpoint: boundary in the match cycle does not count
    setch(1, 3'd1, 2'd1, 32'h200, 0);
    idle(); rd_vld = 1; rd_addr = 32'h200; int_boundary = 1; step();
    chk(halt_req == 0, "R6 same-cycle boundary", 32'(halt_req), 0);
    idle(); step();
    chk(halt_req == 0, "R6 waiting", 32'(halt_req), 0);
    idle(); int_boundary = 1; step();
    chk(halt_req == 1, "R6 boundary halt", 32'(halt_req), 1);
    // R7 interrupt mode on write data
    setch(2, 3'd3, 2'd3, 32'hBEEF, 0);
    idle(); wr_vld = 1; wr_data = 32'hBEEF; step();
    chk(rti_req == 1, "R7 rti mode", 32'(rti_req), 1);
    // R8 AND groups: empty stays low, full fires; R10 routing
    setch(2, 3'd2, 2'd1, 32'h40, 0);
    setch(3, 3'd3, 2'd1, 32'h41, 0);
    and_sel = 16'h00C0; or_sel = 16'h0400; evt_to_rti = 8'h02;
    idle(); wr_vld = 1; wr_addr = 32'h40; wr_data = 32'h41; step();
    chk(and_evt == 4'b0010, "R8 and full", 32'(and_evt), 32'h2);
    chk(rti_req == 1, "R10 routed", 32'(rti_req), 1);
    idle(); wr_vld = 1; wr_addr = 32'h40; wr_data = 0; step();
    chk(and_evt == 0 && or_evt == 4'b0100, "R9 or partial", {and_evt, or_evt}, 8'h04);
    idle(); int_boundary = 1; step();

    // random
    for (int n = 0; n < 4000; n++) begin
      if (n % 100 == 0) begin
        for (int i = 0; i < NCH; i++)
          setch(i, 3'($urandom_range(0, 5)), 2'($urandom), 32'h1000 * i + 32'($urandom_range(0, 7)),
                32'($urandom_range(0, 3)));
        and_sel = 16'($urandom); or_sel = 16'($urandom); evt_to_rti = 8'($urandom);
        if (n % 300 == 0) and_sel[3:0] = 0;
      end
      idle();
      fetch_vld = $urandom_range(0, 1); rd_vld = $urandom_range(0, 1);
      wr_vld = $urandom_range(0, 1); vpc_vld = $urandom_range(0, 1);
      prog_addr = 32'h1000 * $urandom_range(0, 3) + 32'($urandom_range(0, 7));
      rd_addr   = 32'h1000 * $urandom_range(0, 3) + 32'($urandom_range(0, 7));
      wr_addr   = 32'h1000 * $urandom_range(0, 3) + 32'($urandom_range(0, 7));
      wr_data   = 32'h1000 * $urandom_range(0, 3) + 32'($urandom_range(0, 7));
      vpc       = 32'h1000 * $urandom_range(0, 3) + 32'($urandom_range(0, 7));
      fetch_slot = 2'($urandom); dec2_slot = 2'($urandom);
      dec2_go = $urandom_range(0, 2) != 0; flush = $urandom_range(0, 9) == 0;
      dbg_attached = $urandom_range(0, 3) != 0; int_boundary = $urandom_range(0, 3) == 0;
      step();
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule